// File: doc/BRIEF.md
# Multi-rail power sequencing supervisor

A clocked controller for a card that carries several multi-voltage devices. It brings up five on-card supply rails in a fixed, interleaved order once both card input supplies (5 V and 3.3 V) report good. It holds the processor in reset for a timed stretch after its supplies are stable, then reports that the card is good. While the card runs, it watches every good flag each cycle. A fault, or a rail that never comes up, starts an ordered shutdown. That shutdown shorts the processor I/O rail to its core rail, waits for the decoupling capacitors to discharge, and then removes the core rail. After that the controller goes back to waiting for the inputs, so power is recycled.

All good flags are synchronous, active-high inputs from external comparators. All outputs are active-high enables, except the processor reset, which is active-low. Three parameters set the reset stretch, the discharge wait and the per-stage power-up timeout in milliseconds. The controller turns them into clock cycles from a clock-frequency parameter in kHz.

Top module: `rail_seq_supervisor`

## Requirements
- R1: After reset, and in the idle wait, every enable (`en_ldo18`, `en_sw15`, `en_sw33`, `en_conv25`, `en_short`) is 0, `cpu_rst_n` is 0, `card_ok` is 0 and `fault_flag` is 0. The power-up does not start until `in5_ok` and `in3_ok` are both 1.
- R2: Power-up begins with `en_ldo18` and `en_sw15`, which rise in the same cycle while `en_sw33` is still 0.
- R3: `en_sw33` rises only in the cycle after `core18_ok` and `core15_ok` are both seen at 1.
- R4: `en_conv25` rises only in the cycle after `sharedio33_ok` is seen at 1.
- R5: With `en_conv25` on, the first cycle in which all seven good flags are 1 starts the reset stretch. `cpu_rst_n` rises exactly HOLD_MS*CLK_KHZ + 1 cycles after that cycle.
- R6: `card_ok` rises together with `cpu_rst_n`. Both stay 1 while all seven good flags stay 1.
- R7: If any good flag is 0 while `card_ok` is 1, then in the next cycle `card_ok` is 0 and `cpu_rst_n` is 0.
- R8: In the first shutdown cycle, `en_conv25`, `en_sw15` and `en_sw33` are 0 and `en_short` is 1, while `en_ldo18` is still 1.
- R9: `en_ldo18` stays 1 for exactly DISCH_MS*CLK_KHZ cycles of shutdown. It then drops while `en_short` is still 1.
- R10: One cycle after `en_ldo18` drops, `en_short` clears and the controller is idle. If the inputs are good, it starts a new power-up.
- R11: If the awaited flags of a power-up stage are not good within TMO_MS*CLK_KHZ cycles of that stage's enable rising, shutdown starts in the cycle after the last counted cycle. The stages are: both core flags after `en_ldo18`, `sharedio33_ok` after `en_sw33`, and all flags after `en_conv25`.
- R12: `fault_flag` rises with `en_short` when shutdown is caused by a fault or a timeout. It stays 1 until the controller returns to idle.
- R13: A good flag that drops during the reset stretch starts shutdown in the next cycle, and `cpu_rst_n` is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in5_ok | input | 1 | Card 5 V input good |
| in3_ok | input | 1 | Card 3.3 V input good |
| core18_ok | input | 1 | 1.8 V processor core good |
| core15_ok | input | 1 | 1.5 V FPGA core good |
| cpuio33_ok | input | 1 | 3.3 V processor I/O good |
| sharedio33_ok | input | 1 | 3.3 V shared FPGA/ASIC I/O good |
| asic25_ok | input | 1 | 2.5 V ASIC core good |
| en_ldo18 | output | 1 | 1.8 V regulator enable |
| en_sw15 | output | 1 | 1.5 V core switch enable |
| en_sw33 | output | 1 | 3.3 V I/O switch enable (processor and shared) |
| en_conv25 | output | 1 | 2.5 V converter enable |
| en_short | output | 1 | I/O-to-core shorting switch enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| card_ok | output | 1 | Card powered up and healthy |
| fault_flag | output | 1 | Shutdown caused by fault or timeout |

## Verification
The hardest situations to reach are those where a rail drops or stalls at a chosen moment inside a multi-step sequence: a fault in normal running, a fault partway through the reset stretch, and a rail that never reports good at one specific stage. The bench models each rail as a flag that follows its enable after a randomly drawn delay. On top of that model it has a kill mask and a stall mask, which a directed task sets at a chosen cycle. This places a fault or a timeout in each stage and checks the exact cycle counts of the stretch, the discharge and the timeout.

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor #(
  parameter int CLK_KHZ  = 200000,
  parameter int HOLD_MS  = 60,
  parameter int DISCH_MS = 5,
  parameter int TMO_MS   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in5_ok,
  input  logic in3_ok,
  input  logic core18_ok,
  input  logic core15_ok,
  input  logic cpuio33_ok,
  input  logic sharedio33_ok,
  input  logic asic25_ok,
  output logic en_ldo18,
  output logic en_sw15,
  output logic en_sw33,
  output logic en_conv25,
  output logic en_short,
  output logic cpu_rst_n,
  output logic card_ok,
  output logic fault_flag
);
  localparam int HOLD_CYC  = CLK_KHZ * HOLD_MS;
  localparam int DISCH_CYC = CLK_KHZ * DISCH_MS;
  localparam int TMO_CYC   = CLK_KHZ * TMO_MS;
  localparam int MAX_A     = HOLD_CYC > DISCH_CYC ? HOLD_CYC : DISCH_CYC;
  localparam int MAX_C     = MAX_A > TMO_CYC ? MAX_A : TMO_CYC;
  localparam int CW        = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    S_WAIT, S_CORE, S_IO, S_ASIC, S_HOLD, S_RUN, S_DISCH, S_DROP
  } st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt;

  wire inputs_ok = in5_ok & in3_ok;
  wire all_ok    = inputs_ok & core18_ok & core15_ok & cpuio33_ok & sharedio33_ok & asic25_ok;
  wire tmo_hit   = cnt == CW'(TMO_CYC - 1);
  wire hold_hit  = cnt == CW'(HOLD_CYC - 1);
  wire disch_hit = cnt == CW'(DISCH_CYC - 1);
  wire timed     = st inside {S_CORE, S_IO, S_ASIC, S_HOLD, S_DISCH};

  always_comb begin
    st_nx = st;
    case (st)
      S_WAIT:  if (inputs_ok) st_nx = S_CORE;
      S_CORE:  if (core18_ok && core15_ok) st_nx = S_IO;
               else if (tmo_hit) st_nx = S_DISCH;
      S_IO:    if (sharedio33_ok) st_nx = S_ASIC;
               else if (tmo_hit) st_nx = S_DISCH;
      S_ASIC:  if (all_ok) st_nx = S_HOLD;
               else if (tmo_hit) st_nx = S_DISCH;
      S_HOLD:  if (!all_ok) st_nx = S_DISCH;
               else if (hold_hit) st_nx = S_RUN;
      S_RUN:   if (!all_ok) st_nx = S_DISCH;
      S_DISCH: if (disch_hit) st_nx = S_DROP;
      S_DROP:  st_nx = S_WAIT;
      default: st_nx = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_WAIT;
      cnt        <= '0;
      fault_flag <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st || !timed) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
      if (st_nx == S_DISCH && st != S_DISCH) fault_flag <= 1'b1;
      else if (st_nx == S_WAIT && st != S_WAIT) fault_flag <= 1'b0;
    end
  end

  assign en_ldo18  = st inside {S_CORE, S_IO, S_ASIC, S_HOLD, S_RUN, S_DISCH};
  assign en_sw15   = st inside {S_CORE, S_IO, S_ASIC, S_HOLD, S_RUN};
  assign en_sw33   = st inside {S_IO, S_ASIC, S_HOLD, S_RUN};
  assign en_conv25 = st inside {S_ASIC, S_HOLD, S_RUN};
  assign en_short  = st inside {S_DISCH, S_DROP};
  assign cpu_rst_n = st == S_RUN;
  assign card_ok   = st == S_RUN;
endmodule

// File: rtl/rail_seq_supervisor_chk.sv
module rail_seq_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic in5_ok,
  input logic in3_ok,
  input logic core18_ok,
  input logic core15_ok,
  input logic cpuio33_ok,
  input logic sharedio33_ok,
  input logic asic25_ok,
  input logic en_ldo18,
  input logic en_sw15,
  input logic en_sw33,
  input logic en_conv25,
  input logic en_short,
  input logic cpu_rst_n,
  input logic card_ok,
  input logic fault_flag
);
  wire all_ok = in5_ok & in3_ok & core18_ok & core15_ok & cpuio33_ok & sharedio33_ok & asic25_ok;

  assert_core_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_ldo18) |-> en_sw15 && !en_sw33);
  assert_io_after_cores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_sw33) |-> $past(core18_ok && core15_ok));
  assert_asic_after_io_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_conv25) |-> $past(sharedio33_ok));
  assert_release_needs_cpu_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(cpuio33_ok && core18_ok));
  assert_ok_with_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_ok |-> cpu_rst_n);
  assert_fault_drops_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_ok && !all_ok |=> !card_ok && !cpu_rst_n);
  assert_shutdown_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_sw33) |-> en_short && !en_conv25 && !en_sw15);
  assert_core_off_shorted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_ldo18) |-> en_short);
  assert_short_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_short && !en_ldo18 |=> !en_short);
  assert_flag_with_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> en_short);
endmodule

bind rail_seq_supervisor rail_seq_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in5_ok(in5_ok), .in3_ok(in3_ok),
  .core18_ok(core18_ok), .core15_ok(core15_ok), .cpuio33_ok(cpuio33_ok),
  .sharedio33_ok(sharedio33_ok), .asic25_ok(asic25_ok),
  .en_ldo18(en_ldo18), .en_sw15(en_sw15), .en_sw33(en_sw33), .en_conv25(en_conv25),
  .en_short(en_short), .cpu_rst_n(cpu_rst_n), .card_ok(card_ok), .fault_flag(fault_flag)
);

// File: tb/rail_seq_supervisor_bench.sv
`timescale 1ns/1ps
module rail_seq_supervisor_bench;
  localparam int KHZ = 2;
  localparam int HOLD = KHZ * 60;
  localparam int DISCH = KHZ * 5;
  localparam int TMO = KHZ * 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in5_ok = 1'b0, in3_ok = 1'b0;
  logic core18_ok, core15_ok, cpuio33_ok, sharedio33_ok, asic25_ok;
  logic en_ldo18, en_sw15, en_sw33, en_conv25, en_short, cpu_rst_n, card_ok, fault_flag;

  always #2.5 clk = ~clk;

  rail_seq_supervisor #(.CLK_KHZ(KHZ), .HOLD_MS(60), .DISCH_MS(5), .TMO_MS(20)) u_rail_seq_supervisor (
    .clk(clk), .rst_n(rst_n), .in5_ok(in5_ok), .in3_ok(in3_ok),
    .core18_ok(core18_ok), .core15_ok(core15_ok), .cpuio33_ok(cpuio33_ok),
    .sharedio33_ok(sharedio33_ok), .asic25_ok(asic25_ok),
    .en_ldo18(en_ldo18), .en_sw15(en_sw15), .en_sw33(en_sw33), .en_conv25(en_conv25),
    .en_short(en_short), .cpu_rst_n(cpu_rst_n), .card_ok(card_ok), .fault_flag(fault_flag));

  // rail model: 0 core18, 1 core15, 2 cpu io, 3 shared io, 4 asic core
  logic [4:0] en_v, ok_v;
  logic [4:0] kill = '0, stall = '0;
  int dly [5];
  int rcnt [5];
  assign en_v = {en_conv25, en_sw33, en_sw33, en_sw15, en_ldo18};
  always @(posedge clk)
    for (int i = 0; i < 5; i++)
      if (!en_v[i]) rcnt[i] <= 0;
      else if (rcnt[i] < 1000) rcnt[i] <= rcnt[i] + 1;
  always_comb
    for (int i = 0; i < 5; i++)
      ok_v[i] = en_v[i] && rcnt[i] >= dly[i] && !stall[i] && !kill[i];
  assign {asic25_ok, sharedio33_ok, cpuio33_ok, core15_ok, core18_ok} = ok_v;
  wire all_ok = in5_ok & in3_ok & (&ok_v);

  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic bit outs_idle();
    return !en_ldo18 && !en_sw15 && !en_sw33 && !en_conv25 && !en_short && !cpu_rst_n && !card_ok;
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pick_delays();
    for (int i = 0; i < 5; i++) dly[i] = 1 + int'($urandom % 20);
  endtask

  task automatic ramp_up();
    while (!en_ldo18 && !en_sw15) @(negedge clk);
    chk(en_ldo18 && en_sw15 && !en_sw33, "R2", {en_ldo18, en_sw15, en_sw33}, 3'b110);
    while (!en_sw33) @(negedge clk);
    chk(core18_ok && core15_ok, "R3", {core18_ok, core15_ok}, 2'b11);
    while (!en_conv25) @(negedge clk);
    chk(sharedio33_ok, "R4", sharedio33_ok, 1);
    while (!all_ok) @(negedge clk);
  endtask

  task automatic hold_release();
    int k = 0;
    while (!cpu_rst_n && k < HOLD + 10) begin
      @(negedge clk);
      k++;
    end
    chk(k == HOLD + 1, "R5", k, HOLD + 1);
    chk(card_ok, "R6", card_ok, 1);
  endtask

  task automatic inject(input int idx);
    if (idx == 0) in5_ok = 1'b0;
    else if (idx == 1) in3_ok = 1'b0;
    else kill[idx-2] = 1'b1;
    @(negedge clk);
    chk(!card_ok && !cpu_rst_n, "R7", {card_ok, cpu_rst_n}, 0);
    chk(!en_conv25 && !en_sw15 && !en_sw33 && en_short && en_ldo18, "R8",
        {en_conv25, en_sw15, en_sw33, en_short, en_ldo18}, 5'b00011);
    chk(fault_flag, "R12", fault_flag, 1);
    in5_ok = 1'b1; in3_ok = 1'b1; kill = '0;
    repeat (DISCH - 1) @(negedge clk);
    chk(en_ldo18, "R9", en_ldo18, 1);
    @(negedge clk);
    chk(!en_ldo18 && en_short, "R9", {en_ldo18, en_short}, 2'b01);
    @(negedge clk);
    chk(!en_short && !fault_flag && outs_idle(), "R10", {en_short, fault_flag}, 0);
    @(negedge clk);
    chk(en_ldo18 && en_sw15, "R10", {en_ldo18, en_sw15}, 3);
  endtask

  task automatic stall_stage(input int st_idx);
    int k = 0;
    pick_delays();
    stall = '0;
    stall[st_idx] = 1'b1;
    if (st_idx == 1) while (!en_ldo18) @(negedge clk);
    else if (st_idx == 3) while (!en_sw33) @(negedge clk);
    else while (!en_conv25) @(negedge clk);
    while (!en_short && k < TMO + 10) begin
      @(negedge clk);
      k++;
    end
    chk(k == TMO, "R11", k, TMO);
    chk(fault_flag && !cpu_rst_n && !card_ok, "R12", fault_flag, 1);
    stall = '0;
    while (en_short) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd41));
    pick_delays();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(outs_idle() && !fault_flag, "R1", {en_ldo18, cpu_rst_n, card_ok, fault_flag}, 0);
    repeat (20) @(negedge clk);
    chk(outs_idle(), "R1", en_ldo18, 0);
    in5_ok = 1'b1;
    repeat (10) @(negedge clk);
    chk(outs_idle(), "R1", en_ldo18, 0);
    in5_ok = 1'b0; in3_ok = 1'b1;
    repeat (10) @(negedge clk);
    chk(outs_idle(), "R1", en_ldo18, 0);
    in5_ok = 1'b1;

    for (int it = 0; it < 8; it++) begin
      int run_len = 5 + int'($urandom % 60);
      bit held = 1'b1;
      ramp_up();
      hold_release();
      for (int c = 0; c < run_len; c++) begin
        @(negedge clk);
        held &= card_ok && cpu_rst_n;
      end
      chk(held, "R6", held, 1);
      inject(int'($urandom % 7));
      pick_delays();
    end

    begin
      int wait_n = 1 + int'($urandom % (HOLD - 5));
      bit rel = 1'b0;
      ramp_up();
      for (int c = 0; c < wait_n; c++) begin
        @(negedge clk);
        rel |= cpu_rst_n;
      end
      kill[0] = 1'b1;
      @(negedge clk);
      chk(!rel && !cpu_rst_n && en_short && fault_flag, "R13", {rel, en_short, fault_flag}, 3'b011);
      kill = '0;
      while (en_short) @(negedge clk);
    end

    stall_stage(1);
    stall_stage(3);
    stall_stage(4);

    pick_delays();
    ramp_up();
    hold_release();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule